// File: doc/BRIEF.md
# Dual-Clock Stream FIFO with Occupancy Counts

This block buffers a stream of data words between a producer and a consumer that may run on unrelated clocks. Both sides use a valid/ready handshake: a word moves on a clock edge where the sender's valid and the receiver's ready are both high. Storage is a power-of-two array. Each side keeps its own binary pointer, which carries one extra wrap bit so that a full array can be told apart from an empty one. Each pointer crosses into the other clock domain as a Gray code through a short chain of flops. Each chain is cleared by the reset of the domain it samples into.

The write side reports `room`, the number of free storage entries. The read side reports `level`, the number of words held in storage. A parameter selects how the read port is built. In direct mode the storage output drives the read port itself. In registered mode one pipeline register sits in front of the consumer. The word parked in that register is no longer in storage, so `level` can read one lower than the number of words the consumer has still to receive. Because of this, the registered stage can be omitted and rebuilt by the surrounding logic instead.

Top module: `occ_stream_fifo`

## Requirements
- R1: While and after reset with no traffic, `room` equals DEPTH (8 by default), `s_ready` is 1, `level` is 0 and `m_valid` is 0.
- R2: Each accepted write lowers `room` by exactly one, seen in the write-clock cycle that follows the accepting edge, as long as no read is in flight. `s_ready` is 0 exactly when `room` is 0. While `s_ready` is 0, a high `s_valid` changes neither `room` nor the stream contents.
- R3: `level` equals the number of words held in the storage array. It never exceeds DEPTH and never falls except after a read from storage.
- R4: Words leave on `m_data` in the order they were accepted on `s_data`, each exactly once and unchanged.
- R5: Once both sides have been idle long enough for the pointer synchronizers to settle, `room + level` equals DEPTH.
- R6: While `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and `m_data` stays unchanged at the next read-clock edge.
- R7: In registered mode (the default), the first word written into an empty FIFO moves into the output register. After settling, that gives `m_valid` = 1, `level` = 0 and `room` = DEPTH. For k written words with no reads, `level` settles to k-1.
- R8: Pointers cross between domains only as Gray codes, changing by at most one bit per source cycle. Under concurrent, irregular traffic on unrelated clocks, every word is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| s_valid | input | 1 | Producer has a word on s_data |
| s_data | input | DATA_W | Word offered by the producer |
| s_ready | output | 1 | FIFO can accept a word this cycle |
| room | output | ADDR_W+1 | Free storage entries |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| m_valid | output | 1 | A word is presented on m_data |
| m_data | output | DATA_W | Word presented to the consumer |
| m_ready | input | 1 | Consumer takes the word this cycle |
| level | output | ADDR_W+1 | Words held in storage |

## Verification
A corrupted pointer or a badly synchronized Gray value appears at the ports within a few cycles of the other clock. It shows as a `room + level` sum that does not reach DEPTH once the FIFO settles, as a lost, repeated or reordered word on `m_data`, or as `s_ready` going low too early or too late. The bench sweeps every fill count from empty to completely full, including the word held in the output register, and checks both counts arithmetically. It then runs irregular concurrent traffic and checks that the stream comes through intact. A flaw in the output stage shows on the first stalled cycle as a changed `m_data` or a dropped `m_valid`.

// File: rtl/sfifo_pkg.sv
`timescale 1ns/1ps
package sfifo_pkg;
    // How the read port is built
    typedef enum logic {
        OUT_DIRECT     = 1'b0,
        OUT_REGISTERED = 1'b1
    } out_mode_e;
endpackage

// File: rtl/sfifo_sync.sv
`timescale 1ns/1ps
// Carries a Gray-coded pointer into the destination domain and returns it
// converted to binary. The flops are cleared by the destination reset.
module sfifo_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= gray_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    always_comb begin
        for (int i = 0; i < W; i++) bin_out[i] = ^(stg[STAGES-1] >> i);
    end
endmodule

// File: rtl/sfifo_wr_ctl.sv
`timescale 1ns/1ps
module sfifo_wr_ctl #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    input  logic [ADDR_W:0]   rd_ptr_seen,
    output logic              s_ready,
    output logic              push,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W:0]   wr_gray,
    output logic [ADDR_W:0]   room
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PW-1:0] wr_bin, wr_nxt, used;

    assign used    = wr_bin - rd_ptr_seen;
    assign room    = PW'(DEPTH) - used;
    assign s_ready = (room != '0);
    assign push    = s_valid & s_ready;
    assign wr_addr = wr_bin[ADDR_W-1:0];
    assign wr_nxt  = wr_bin + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else if (push) begin
            wr_bin  <= wr_nxt;
            wr_gray <= wr_nxt ^ (wr_nxt >> 1);
        end
    end

    // R2: free count stays within the array size
    a_r2_room_bound: assert property (@(posedge clk) disable iff (rst)
        room <= PW'(DEPTH));
    // R2: free count only drops after a write
    a_r2_room_drop: assert property (@(posedge clk) disable iff (rst)
        !push |=> room >= $past(room));
    // R8: exported pointer moves one Gray step at a time
    a_r8_gray_step: assert property (@(posedge clk) disable iff (rst)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);
endmodule

// File: rtl/sfifo_rd_ctl.sv
`timescale 1ns/1ps
module sfifo_rd_ctl #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_ready,
    input  logic [ADDR_W:0]   wr_ptr_seen,
    output logic              fifo_valid,
    output logic              pop,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   rd_gray,
    output logic [ADDR_W:0]   level
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PW-1:0] rd_bin, rd_nxt;

    assign level      = wr_ptr_seen - rd_bin;
    assign fifo_valid = (level != '0);
    assign pop        = fifo_valid & fifo_ready;
    assign rd_addr    = rd_bin[ADDR_W-1:0];
    assign rd_nxt     = rd_bin + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else if (pop) begin
            rd_bin  <= rd_nxt;
            rd_gray <= rd_nxt ^ (rd_nxt >> 1);
        end
    end

    // R3: fill count stays within the array size
    a_r3_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= PW'(DEPTH));
    // R3: fill count only drops after a read from storage
    a_r3_level_drop: assert property (@(posedge clk) disable iff (rst)
        !pop |=> level >= $past(level));
    // R8: exported pointer moves one Gray step at a time
    a_r8_rd_gray_step: assert property (@(posedge clk) disable iff (rst)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

// File: rtl/sfifo_out_stage.sv
`timescale 1ns/1ps
module sfifo_out_stage
    import sfifo_pkg::*;
#(
    parameter int        DATA_W   = 8,
    parameter out_mode_e OUT_MODE = OUT_REGISTERED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_valid,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_ready,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    input  logic              m_ready
);
    generate
        if (OUT_MODE == OUT_REGISTERED) begin : g_reg
            logic              hold_v;
            logic [DATA_W-1:0] hold_d;
            assign fifo_ready = !hold_v || m_ready;
            always_ff @(posedge clk) begin
                if (rst) begin
                    hold_v <= 1'b0;
                    hold_d <= '0;
                end else if (fifo_ready) begin
                    hold_v <= fifo_valid;
                    if (fifo_valid) hold_d <= fifo_data;
                end
            end
            assign m_valid = hold_v;
            assign m_data  = hold_d;
        end else begin : g_direct
            assign fifo_ready = m_ready;
            assign m_valid    = fifo_valid;
            assign m_data     = fifo_data;
        end
    endgenerate

    // R6: a stalled word stays put
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
endmodule

// File: rtl/occ_stream_fifo.sv
`timescale 1ns/1ps
module occ_stream_fifo
    import sfifo_pkg::*;
#(
    parameter int        DATA_W      = 8,
    parameter int        ADDR_W      = 3,
    parameter int        SYNC_STAGES = 2,
    parameter out_mode_e OUT_MODE    = OUT_REGISTERED
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    output logic [ADDR_W:0]   room,
    input  logic              rd_clk,
    input  logic              rd_rst,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    input  logic              m_ready,
    output logic [ADDR_W:0]   level
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic              push, pop, fifo_valid, fifo_ready;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [PW-1:0]     wr_gray, rd_gray, wr_seen, rd_seen;
    logic [DATA_W-1:0] store [DEPTH];

    sfifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .s_valid(s_valid), .rd_ptr_seen(rd_seen),
        .s_ready(s_ready), .push(push), .wr_addr(wr_addr), .wr_gray(wr_gray),
        .room(room));

    sfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rd2wr (
        .clk(wr_clk), .rst(wr_rst), .gray_in(rd_gray), .bin_out(rd_seen));

    sfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wr2rd (
        .clk(rd_clk), .rst(rd_rst), .gray_in(wr_gray), .bin_out(wr_seen));

    sfifo_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .fifo_ready(fifo_ready), .wr_ptr_seen(wr_seen),
        .fifo_valid(fifo_valid), .pop(pop), .rd_addr(rd_addr), .rd_gray(rd_gray),
        .level(level));

    always_ff @(posedge wr_clk) begin
        if (push) store[wr_addr] <= s_data;
    end

    sfifo_out_stage #(.DATA_W(DATA_W), .OUT_MODE(OUT_MODE)) u_out (
        .clk(rd_clk), .rst(rd_rst), .fifo_valid(fifo_valid),
        .fifo_data(store[rd_addr]), .fifo_ready(fifo_ready),
        .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready));
endmodule

// File: tb/test_occ_stream_fifo.sv
`timescale 1ns/1ps
module test_occ_stream_fifo;
    localparam int DEPTH = 8;

    logic       wr_clk = 0, rd_clk = 0, wr_rst = 1, rd_rst = 1;
    logic       s_valid = 0, s_ready, m_valid, m_ready = 0;
    logic [7:0] s_data = 0, m_data;
    logic [3:0] room, level;

    always #2   wr_clk = ~wr_clk;   // 250 MHz
    always #3.5 rd_clk = ~rd_clk;

    occ_stream_fifo i_occ_stream_fifo (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .room(room), .rd_clk(rd_clk), .rd_rst(rd_rst),
        .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready), .level(level));

    int n_run = 0, n_fail = 0;
    int wr_n = 0, rd_n = 0, rd_mode = 0;
    logic [7:0] exp_q [0:1023];
    logic [15:0] lfsr = 16'hACE1;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic push_word(input logic [7:0] d);
        @(negedge wr_clk);
        s_valid = 1; s_data = d;
        while (!s_ready) @(negedge wr_clk);
        exp_q[wr_n] = d; wr_n++;
        @(posedge wr_clk); #1 s_valid = 0;
    endtask

    task automatic settle();
        repeat (20) @(negedge wr_clk);
    endtask

    task automatic drain();
        rd_mode = 1;
        while (rd_n < wr_n) @(negedge rd_clk);
        settle();
        rd_mode = 0;
        settle();
    endtask

    // Reader: drives m_ready, checks order (R4) and stall hold (R6)
    initial begin
        bit         prev_stall = 0;
        logic [7:0] prev_data  = 0;
        int         cnt = 0;
        forever begin
            @(negedge rd_clk);
            if (rd_mode == 1) m_ready = 1;
            else if (rd_mode == 2) m_ready = (cnt % 3) != 0;
            else m_ready = 0;
            cnt++;
            if (prev_stall) begin
                chk(m_valid == 1, "R6 valid held", m_valid, 1);
                chk(m_data == prev_data, "R6 data held", m_data, prev_data);
            end
            if (m_valid && m_ready) begin
                chk(rd_n < wr_n, "R4 no extra word", rd_n, wr_n);
                chk(m_data == exp_q[rd_n], "R4 order", m_data, exp_q[rd_n]);
                rd_n++;
            end
            prev_stall = m_valid && !m_ready;
            prev_data  = m_data;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge rd_clk);
        wr_rst = 0; rd_rst = 0;
        settle();
        // R1 reset state
        chk(room == DEPTH, "R1 room", room, DEPTH);
        chk(s_ready == 1, "R1 s_ready", s_ready, 1);
        chk(level == 0, "R1 level", level, 0);
        chk(m_valid == 0, "R1 m_valid", m_valid, 0);

        // Sweep every fill count: R3, R5, R7
        for (int k = 0; k <= DEPTH + 1; k++) begin
            for (int j = 0; j < k; j++) push_word(8'(k * 16 + j));
            settle();
            chk(level == ((k == 0) ? 0 : k - 1), "R3 R7 level after k writes", level, (k == 0) ? 0 : k - 1);
            chk(m_valid == (k > 0), "R7 m_valid", m_valid, k > 0);
            chk(room + level == DEPTH, "R5 room+level", room + level, DEPTH);
            if (k == DEPTH + 1) chk(s_ready == 0, "R2 s_ready at full", s_ready, 0);
            drain();
            chk(m_valid == 0, "R4 drained", m_valid, 0);
        end

        // Fill step by step: R2 decrement and ignored writes
        push_word(8'h11);
        settle();
        chk(room == DEPTH, "R7 room with output register full", room, DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            push_word(8'(8'h20 + i));
            @(negedge wr_clk);
            chk(room == DEPTH - 1 - i, "R2 room after write", room, DEPTH - 1 - i);
        end
        chk(s_ready == 0, "R2 s_ready low at room 0", s_ready, 0);
        @(negedge wr_clk);
        s_valid = 1; s_data = 8'hEE;
        for (int i = 0; i < 6; i++) begin
            @(negedge wr_clk);
            chk(room == 0, "R2 ignored write room", room, 0);
        end
        s_valid = 0;
        settle();
        chk(level == DEPTH, "R3 level full", level, DEPTH);
        chk(room + level == DEPTH, "R5 full sum", room + level, DEPTH);
        // Drain with stalls (R4, R6); 0xEE must not appear
        rd_mode = 2;
        while (rd_n < wr_n) @(negedge rd_clk);
        settle();
        rd_mode = 0;
        settle();
        chk(m_valid == 0, "R2 ignored word absent", m_valid, 0);

        // Concurrent irregular traffic: R8
        rd_mode = 2;
        for (int i = 0; i < 150; i++) begin
            step_lfsr();
            if (lfsr[0]) @(negedge wr_clk);
            push_word(lfsr[15:8]);
        end
        while (rd_n < wr_n) @(negedge rd_clk);
        settle();
        rd_mode = 0;
        settle();
        chk(rd_n == wr_n, "R8 all delivered", rd_n, wr_n);
        chk(room == DEPTH, "R8 room idle", room, DEPTH);
        chk(level == 0, "R8 level idle", level, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule